// File: doc/BRIEF.md
# Constant-Coefficient Complex Multiplier

The block multiplies a stream of signed complex samples by one complex coefficient that is fixed when the block is built. One sample can be accepted on every clock. Each sample is marked by a valid strobe, and the result leaves with its own valid strobe a fixed number of cycles later. The block has no multiplier primitive and no stall input. Upstream logic drives a sample and the strobe in the same cycle. Downstream logic takes a result in every cycle in which the output strobe is high.

The block forms three real products rather than four. The real part of the result is rebuilt as (Dr+Di)·(Cr−Ci) + (Dr·Ci − Di·Cr). The imaginary part is Dr·Ci + Di·Cr. The difference Cr−Ci is a constant worked out at elaboration.

Each constant product comes from two tables of precomputed partial products. The low table is indexed by the unsigned low 9 bits of the operand. The high table is indexed by the signed upper bits. The product is the high entry shifted left by 9, plus the low entry. The coefficient parameters fill both tables at elaboration, so nothing is loaded at run time.

Top module: `cmul_const`

## Requirements
- R1: While rst_ni is low, valid_o, re_o and im_o are all zero. Samples in the pipeline when reset asserts are discarded and never produce a valid_o pulse.
- R2: im_o equals Dr·Ci + Di·Cr exactly, as a 37-bit two's-complement value, where Dr = re_i, Di = im_i, Cr = COEF_RE and Ci = COEF_IM.
- R3: re_o equals Dr·Cr − Di·Ci exactly, as a 37-bit two's-complement value.
- R4: Each of the three constant products (Dr+Di)·(Cr−Ci), Dr·Ci and Di·Cr is exact over the full operand range. This includes an operand of −131072 and a sum Dr+Di of −262144.
- R5: valid_o equals valid_i delayed by three rising edges. The result for a sample sampled at edge k is on the outputs after edge k+2.
- R6: No output overflows for any 18-bit signed inputs and any 18-bit signed coefficient pair, including the most negative and most positive extremes.
- R7: Samples presented on consecutive cycles each produce their own correct result on consecutive cycles.
- R8: A cycle with valid_i low yields valid_o low three edges later, whatever the data inputs carry in that cycle.
- R9: The coefficient is set only by the COEF_RE and COEF_IM parameters. An instance built with different values produces results for those values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks a sample on re_i/im_i |
| re_i | input | 18 | Signed real part of the sample |
| im_i | input | 18 | Signed imaginary part of the sample |
| valid_o | output | 1 | Marks a result on re_o/im_o |
| re_o | output | 37 | Signed real part of the product |
| im_o | output | 37 | Signed imaginary part of the product |

## Verification
A corrupt partial-product entry appears only when a sample's low or high segment selects that entry. It then shows as a wrong re_o or im_o exactly three edges after that sample. Samples that miss the entry stay correct, so the stimulus spreads across segment values with extremes, sign flips and random data. A wrong Cr−Ci constant or a wrong sign in the recombination corrupts re_o for nearly every nonzero sample, while im_o stays correct. A slipped or stuck valid stage is visible on valid_o within three cycles of the first sample or bubble.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  localparam int DATA_W   = 18;
  localparam int COEF_W   = 18;
  localparam int SEG_LO_W = 9;
  localparam int PIPE_LAT = 3;
endpackage

// File: rtl/cmul_lut_mult.sv
// Constant multiplier: two segment tables, registered, recombined.
module cmul_lut_mult #(
  parameter int OP_W   = 18,
  parameter int CF_W   = 18,
  parameter int LO_W   = 9,
  parameter logic signed [CF_W-1:0] COEF = '0,
  parameter int PROD_W = OP_W + CF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [OP_W-1:0]   op_i,
  output logic signed [PROD_W-1:0] prod_o
);
  localparam int HI_W = OP_W - LO_W;
  localparam int LO_N = 1 << LO_W;
  localparam int HI_N = 1 << HI_W;
  localparam int LP_W = CF_W + LO_W + 1;
  localparam int HP_W = CF_W + HI_W;

  function automatic logic signed [LP_W-1:0] lo_pp(input int idx);
    logic signed [LP_W-1:0] c;
    logic signed [LP_W-1:0] d;
    c = LP_W'(COEF);
    d = '0;
    d[LO_W-1:0] = LO_W'(idx);
    return c * d;
  endfunction

  function automatic logic signed [HP_W-1:0] hi_pp(input int idx);
    logic signed [HI_W-1:0] h;
    logic signed [HP_W-1:0] c;
    logic signed [HP_W-1:0] d;
    h = HI_W'(idx);
    c = HP_W'(COEF);
    d = HP_W'(h);
    return c * d;
  endfunction

  logic signed [LP_W-1:0] lo_tab [LO_N];
  logic signed [HP_W-1:0] hi_tab [HI_N];

  for (genvar g = 0; g < LO_N; g++) begin : g_lo_tab
    assign lo_tab[g] = lo_pp(g);
  end
  for (genvar g = 0; g < HI_N; g++) begin : g_hi_tab
    assign hi_tab[g] = hi_pp(g);
  end

  logic signed [LP_W-1:0] lo_q;
  logic signed [HP_W-1:0] hi_q;
  logic                   seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      lo_q   <= lo_tab[op_i[LO_W-1:0]];
      hi_q   <= hi_tab[op_i[OP_W-1:LO_W]];
      seen_q <= 1'b1;
    end
  end

  assign prod_o = (PROD_W'(hi_q) <<< LO_W) + PROD_W'(lo_q);

  // R4: recombined table output matches a true multiply of last operand
  assert_prod_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> prod_o == PROD_W'($past(op_i)) * PROD_W'(COEF));

endmodule

// File: rtl/cmul_const.sv
module cmul_const #(
  parameter int DW   = cmul_pkg::DATA_W,
  parameter int CW   = cmul_pkg::COEF_W,
  parameter int LO_W = cmul_pkg::SEG_LO_W,
  parameter logic signed [CW-1:0] COEF_RE = 18'sd12345,
  parameter logic signed [CW-1:0] COEF_IM = -18'sd6789,
  parameter int RW   = DW + CW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] re_i,
  input  logic signed [DW-1:0] im_i,
  output logic                 valid_o,
  output logic signed [RW-1:0] re_o,
  output logic signed [RW-1:0] im_o
);
  localparam int LAT   = cmul_pkg::PIPE_LAT;
  localparam int SUM_W = DW + 1;
  localparam int ACC_W = DW + CW + 2;
  localparam int PX_W  = DW + CW;
  localparam logic signed [CW:0] COEF_D = (CW+1)'(COEF_RE) - (CW+1)'(COEF_IM);

  // stage 1: input registers, operand sum widened by one bit
  logic signed [DW-1:0]    re_q, im_q;
  logic signed [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q  <= '0;
      im_q  <= '0;
      sum_q <= '0;
    end else begin
      re_q  <= re_i;
      im_q  <= im_i;
      sum_q <= SUM_W'(re_i) + SUM_W'(im_i);
    end
  end

  // stage 2: three table multipliers
  logic signed [ACC_W-1:0] p_sum;
  logic signed [PX_W-1:0]  p_rci, p_icr;

  cmul_lut_mult #(
    .OP_W(SUM_W), .CF_W(CW+1), .LO_W(LO_W), .COEF(COEF_D), .PROD_W(ACC_W)
  ) u_mul_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(sum_q), .prod_o(p_sum)
  );

  cmul_lut_mult #(
    .OP_W(DW), .CF_W(CW), .LO_W(LO_W), .COEF(COEF_IM), .PROD_W(PX_W)
  ) u_mul_rci (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(re_q), .prod_o(p_rci)
  );

  cmul_lut_mult #(
    .OP_W(DW), .CF_W(CW), .LO_W(LO_W), .COEF(COEF_RE), .PROD_W(PX_W)
  ) u_mul_icr (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(im_q), .prod_o(p_icr)
  );

  // stage 3: recombine
  logic signed [ACC_W-1:0] acc_re, acc_im;
  assign acc_re = p_sum + ACC_W'(p_rci) - ACC_W'(p_icr);
  assign acc_im = ACC_W'(p_rci) + ACC_W'(p_icr);

  logic signed [RW-1:0] re_q3, im_q3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q3 <= '0;
      im_q3 <= '0;
    end else begin
      re_q3 <= acc_re[RW-1:0];
      im_q3 <= acc_im[RW-1:0];
    end
  end

  // valid shift register
  logic [LAT-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], valid_i};
  end

  assign valid_o = vld_q[LAT-1];
  assign re_o    = re_q3;
  assign im_o    = im_q3;

  // edges since reset, saturating, for the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  assert_no_overflow_re_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_re[ACC_W-1] == acc_re[ACC_W-2]);

  assert_no_overflow_im_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_im[ACC_W-1] == acc_im[ACC_W-2]);

endmodule

// File: tb/tb_cmul_const.sv
`timescale 1ns/1ps
module tb_cmul_const;
  localparam longint CR_A = 12345;
  localparam longint CI_A = -6789;
  localparam longint CR_B = -131072;
  localparam longint CI_B = 131071;
  localparam int NV = 10;
  localparam int VEC_RE [NV] = '{0, 1, -1, 131071, -131072, 1000, -77777, 65536, 12345, -2};
  localparam int VEC_IM [NV] = '{0, -1, 1, 131071, -131072, -50000, 3, -65536, 99999, 131071};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic signed [17:0] dre = '0;
  logic signed [17:0] dim = '0;
  logic va, vb;
  logic signed [36:0] ra, ia, rb, ib;

  always #2 clk = ~clk;

  cmul_const dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .re_i(dre), .im_i(dim),
    .valid_o(va), .re_o(ra), .im_o(ia)
  );

  cmul_const #(.COEF_RE(18'sh20000), .COEF_IM(18'sh1FFFF)) dut_ext (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .re_i(dre), .im_i(dim),
    .valid_o(vb), .re_o(rb), .im_o(ib)
  );

  int checks = 0;
  int fails = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string phase = "R1";

  bit     ev  [3];
  longint era [3];
  longint eia [3];
  longint erb [3];
  longint eib [3];

  function automatic longint mre(input longint dr, input longint di, input longint cr, input longint ci);
    return dr * cr - di * ci;
  endfunction

  function automatic longint mim(input longint dr, input longint di, input longint cr, input longint ci);
    return dr * ci + di * cr;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // expected pipeline: three edges, per R5
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        ev[k] <= 1'b0; era[k] <= 0; eia[k] <= 0; erb[k] <= 0; eib[k] <= 0;
      end
    end else begin
      for (int k = 2; k > 0; k--) begin
        ev[k] <= ev[k-1]; era[k] <= era[k-1]; eia[k] <= eia[k-1];
        erb[k] <= erb[k-1]; eib[k] <= eib[k-1];
      end
      ev[0]  <= vld;
      era[0] <= mre(dre, dim, CR_A, CI_A);
      eia[0] <= mim(dre, dim, CR_A, CI_A);
      erb[0] <= mre(dre, dim, CR_B, CI_B);
      eib[0] <= mim(dre, dim, CR_B, CI_B);
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(ev[2] ? {"R5 valid ", phase} : {"R8 idle ", phase}, longint'(va), longint'(ev[2]));
      check({"R5 valid ext ", phase}, longint'(vb), longint'(ev[2]));
      if (ev[2]) begin
        check({"R3 real ", phase}, ra, era[2]);
        check({"R2 imag ", phase}, ia, eia[2]);
        check({"R9 real ext ", phase}, rb, erb[2]);
        check({"R9 imag ext ", phase}, ib, eib[2]);
      end
    end
  end

  task automatic drive(input bit v, input longint r, input longint i);
    @(negedge clk);
    vld = v;
    dre = 18'(r);
    dim = 18'(i);
  endtask

  task automatic do_reset();
    chk_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    vld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", longint'(va), 0);
    check("R1 reset real", ra, 0);
    check("R1 reset imag", ia, 0);
    check("R1 reset valid ext", longint'(vb), 0);
    check("R1 reset real ext", rb, 0);
    rst_n = 1'b1;
    chk_en = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    do_reset();

    phase = "R7 table";
    for (int n = 0; n < NV; n++) drive(1'b1, VEC_RE[n], VEC_IM[n]);

    phase = "R4 corner";
    drive(1'b1, -131072, -131072);
    drive(1'b0, 5, 5);
    drive(1'b1, -131072, 0);
    drive(1'b1, 0, -131072);
    drive(1'b1, 0, 0);

    phase = "R6 extremes";
    drive(1'b1, 131071, 131071);
    drive(1'b1, -131072, 131071);
    drive(1'b1, 131071, -131072);
    drive(1'b1, -131072, -131072);

    phase = "R8 bubbles";
    drive(1'b1, 777, -888);
    drive(1'b0, 131071, -131072);
    drive(1'b0, -5, 9);
    drive(1'b1, -4321, 4321);
    drive(1'b0, 1, 1);
    drive(1'b1, 511, -512);

    phase = "R1 flush";
    drive(1'b1, 1234, 5678);
    drive(1'b1, -1234, -5678);
    do_reset();
    repeat (5) drive(1'b0, 0, 0);

    phase = "R7 random";
    for (int n = 0; n < 400; n++)
      drive(1'($urandom_range(0, 3) != 0),
            longint'($signed(18'($urandom))),
            longint'($signed(18'($urandom))));

    phase = "drain";
    repeat (5) drive(1'b0, 0, 0);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: got %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule